// File: doc/BRIEF.md
# Device Operating Mode Tracker

This block follows the operating mode of an embedded flash memory device as seen from the command stream and from board-level events. A command decoder upstream presents each received command as a one-cycle strobe with its 6-bit index and 32-bit argument. Separate single-cycle inputs report a power cycle, a hardware reset pulse, the end of the boot stream and an interrupt service request. Two level inputs report whether boot is supported and whether the operating voltage and access mode are valid. The tracker updates a registered mode code, a flag telling whether a relative address has been assigned, and a one-cycle pulse marking a command that the current mode does not allow.

All pins are plain control and status signals. There is no data stream and no back-pressure: each strobe or pulse is consumed in the cycle it is high. Every output is registered, so a change appears one clock after the input that causes it.

Top module: `dev_mode_tracker`

## Requirements
- R1: Mode codes are BOOT=0, IDENT=1, XFER=2, IRQ=3, INACTIVE=4. After the block reset the mode is BOOT, the address flag is 0 and the reject pulse is 0. A power-cycle pulse sets BOOT and clears the address flag in the next cycle from any mode, including INACTIVE, and it overrides every other input.
- R2: A hardware reset pulse sets BOOT and clears the address flag in the next cycle from any mode other than INACTIVE.
- R3: Outside INACTIVE, command index 0 with argument 0xF0F0F0F0 sets BOOT. Command index 0 with any other argument sets IDENT. Either one clears the address flag.
- R4: In BOOT, a boot-done pulse moves the mode to IDENT. When boot-supported is low, BOOT moves to IDENT on the next cycle without waiting for a pulse. With boot-supported high and no event, BOOT persists.
- R5: In IDENT, command index 3 whose argument bits 31:16 are nonzero captures those bits as the address, sets the address flag and moves to XFER. If those bits are zero, the command is rejected and the mode stays IDENT. Other commands in IDENT change nothing.
- R6: Command index 15 moves the mode to INACTIVE from BOOT, IDENT, XFER or IRQ.
- R7: Outside INACTIVE, and with no power cycle and no hardware reset, a low voltage/access-valid input moves the mode to INACTIVE in the next cycle.
- R8: In INACTIVE, every command, hardware reset and voltage change is ignored: the mode stays INACTIVE and no reject pulse is produced. Only a power cycle leaves INACTIVE.
- R9: Command index 40 in XFER moves the mode to IRQ. IRQ can be entered only from XFER. Index 40 in IDENT is rejected.
- R10: IRQ returns to XFER on an interrupt-request pulse, or on any command other than index 0 and index 15.
- R11: The reject output is a one-cycle pulse in the cycle after a rejected command. Rejected commands are: index 3 with a zero address, index 3 outside IDENT, index 40 in IDENT, and any index other than 0 or 15 while in BOOT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| power_cycle | input | 1 | One-cycle pulse: supply was cycled |
| hw_reset | input | 1 | One-cycle pulse: hardware reset pin asserted |
| cmd_valid | input | 1 | Command strobe |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| boot_supported | input | 1 | Boot operation is supported |
| boot_done | input | 1 | One-cycle pulse: boot stream finished |
| volt_ok | input | 1 | Operating voltage and access mode are valid |
| irq_req | input | 1 | One-cycle pulse: interrupt service request |
| mode | output | 3 | Current mode code |
| addr_assigned | output | 1 | A nonzero relative address is held |
| illegal_cmd | output | 1 | Pulse: last command was rejected |

## Verification
The checker asserts on every cycle the behaviours that hold whatever the traffic. A power cycle always lands in BOOT with the flag cleared. Hardware reset and a voltage fault win over commands. INACTIVE never changes without a power cycle and never rejects. IRQ is only reached from XFER, the address flag is never set in BOOT or IDENT, and a reject pulse always follows a command strobe. The directed scenarios show the things that depend on which command was sent: the two index-0 arguments, zero and nonzero address capture, the index-40 round trip and its two exits, the boot-supported shortcut, and the exact index set that is rejected in each mode.

// File: rtl/devmode_pkg.sv
package devmode_pkg;

  typedef enum logic [2:0] {
    MODE_BOOT  = 3'd0,
    MODE_IDENT = 3'd1,
    MODE_XFER  = 3'd2,
    MODE_IRQ   = 3'd3,
    MODE_INACT = 3'd4
  } dev_mode_e;

  typedef struct packed {
    logic go_idle;
    logic boot_key;
    logic set_addr;
    logic addr_zero;
    logic sleep;
    logic irq_cmd;
  } cmd_class_t;

endpackage

// File: rtl/cmd_classifier.sv
module cmd_classifier
  import devmode_pkg::*;
#(
  parameter int CMD_W         = 6,
  parameter int ARG_W         = 32,
  parameter int ADDR_W        = 16,
  parameter int IDX_GO_IDLE   = 0,
  parameter int IDX_SET_ADDR  = 3,
  parameter int IDX_SLEEP     = 15,
  parameter int IDX_IRQ       = 40,
  parameter logic [ARG_W-1:0] BOOT_KEY = 32'hF0F0_F0F0
) (
  input  logic [CMD_W-1:0]  idx,
  input  logic [ARG_W-1:0]  arg,
  output cmd_class_t        cls,
  output logic [ADDR_W-1:0] addr_field
);
  localparam int ADDR_LSB = ARG_W - ADDR_W;

  assign addr_field = arg[ARG_W-1:ADDR_LSB];

  always_comb begin
    cls.go_idle   = (idx == CMD_W'(IDX_GO_IDLE));
    cls.boot_key  = (arg == BOOT_KEY);
    cls.set_addr  = (idx == CMD_W'(IDX_SET_ADDR));
    cls.addr_zero = (addr_field == '0);
    cls.sleep     = (idx == CMD_W'(IDX_SLEEP));
    cls.irq_cmd   = (idx == CMD_W'(IDX_IRQ));
  end
endmodule

// File: rtl/addr_holder.sv
module addr_holder #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              assigned
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (clr)   addr_q <= '0;
    else if (load)  addr_q <= addr_in;
  end

  assign assigned = |addr_q;
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
  import devmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       power_cycle,
  input  logic       hw_reset,
  input  logic       cmd_valid,
  input  cmd_class_t cls,
  input  logic       boot_supported,
  input  logic       boot_done,
  input  logic       volt_ok,
  input  logic       irq_req,
  output dev_mode_e  mode,
  output logic       addr_load,
  output logic       addr_clr,
  output logic       illegal
);
  dev_mode_e mode_q, mode_d;
  logic      bad_d, illegal_q;

  always_comb begin
    mode_d    = mode_q;
    addr_load = 1'b0;
    addr_clr  = 1'b0;
    bad_d     = 1'b0;
    if (power_cycle) begin
      mode_d   = MODE_BOOT;
      addr_clr = 1'b1;
    end else if (mode_q == MODE_INACT) begin
      mode_d = MODE_INACT;
    end else if (hw_reset) begin
      mode_d   = MODE_BOOT;
      addr_clr = 1'b1;
    end else if (!volt_ok) begin
      mode_d = MODE_INACT;
    end else if (cmd_valid) begin
      if (cls.go_idle) begin
        addr_clr = 1'b1;
        mode_d   = cls.boot_key ? MODE_BOOT : MODE_IDENT;
      end else if (cls.sleep) begin
        mode_d = MODE_INACT;
      end else begin
        unique case (mode_q)
          MODE_BOOT: bad_d = 1'b1;
          MODE_IDENT: begin
            if (cls.set_addr) begin
              if (cls.addr_zero) bad_d = 1'b1;
              else begin
                addr_load = 1'b1;
                mode_d    = MODE_XFER;
              end
            end else if (cls.irq_cmd) begin
              bad_d = 1'b1;
            end
          end
          MODE_XFER: begin
            if (cls.set_addr)     bad_d  = 1'b1;
            else if (cls.irq_cmd) mode_d = MODE_IRQ;
          end
          MODE_IRQ: begin
            if (cls.set_addr) bad_d = 1'b1;
            mode_d = MODE_XFER;
          end
          default: mode_d = mode_q;
        endcase
      end
    end else begin
      unique case (mode_q)
        MODE_BOOT: if (boot_done || !boot_supported) mode_d = MODE_IDENT;
        MODE_IRQ:  if (irq_req) mode_d = MODE_XFER;
        default:   mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_BOOT;
      illegal_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      illegal_q <= bad_d;
    end
  end

  assign mode    = mode_q;
  assign illegal = illegal_q;
endmodule

// File: rtl/dev_mode_tracker.sv
module dev_mode_tracker
  import devmode_pkg::*;
#(
  parameter int CMD_W  = 6,
  parameter int ARG_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_cycle,
  input  logic             hw_reset,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_idx,
  input  logic [ARG_W-1:0] cmd_arg,
  input  logic             boot_supported,
  input  logic             boot_done,
  input  logic             volt_ok,
  input  logic             irq_req,
  output logic [2:0]       mode,
  output logic             addr_assigned,
  output logic             illegal_cmd
);
  cmd_class_t        cls;
  logic [ADDR_W-1:0] addr_field;
  dev_mode_e         mode_e;
  logic              addr_load, addr_clr;

  cmd_classifier #(
    .CMD_W (CMD_W),
    .ARG_W (ARG_W),
    .ADDR_W(ADDR_W)
  ) u_cls (
    .idx       (cmd_idx),
    .arg       (cmd_arg),
    .cls       (cls),
    .addr_field(addr_field)
  );

  mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .power_cycle   (power_cycle),
    .hw_reset      (hw_reset),
    .cmd_valid     (cmd_valid),
    .cls           (cls),
    .boot_supported(boot_supported),
    .boot_done     (boot_done),
    .volt_ok       (volt_ok),
    .irq_req       (irq_req),
    .mode          (mode_e),
    .addr_load     (addr_load),
    .addr_clr      (addr_clr),
    .illegal       (illegal_cmd)
  );

  addr_holder #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (addr_load),
    .clr     (addr_clr),
    .addr_in (addr_field),
    .assigned(addr_assigned)
  );

  assign mode = mode_e;
endmodule

// File: rtl/dev_mode_tracker_chk.sv
module dev_mode_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       power_cycle,
  input logic       hw_reset,
  input logic       volt_ok,
  input logic       cmd_valid,
  input logic [2:0] mode,
  input logic       addr_assigned,
  input logic       illegal_cmd
);
  assert_power_boot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    power_cycle |=> (mode == 3'd0 && !addr_assigned));

  assert_hwreset_boot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_reset && !power_cycle && mode != 3'd4) |=> (mode == 3'd0 && !addr_assigned));

  assert_addr_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_assigned |-> (mode == 3'd2 || mode == 3'd3 || mode == 3'd4));

  assert_volt_inactive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!volt_ok && !power_cycle && !hw_reset) |=> (mode == 3'd4));

  assert_inactive_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !power_cycle) |=> (mode == 3'd4 && !illegal_cmd));

  assert_irq_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> ($past(mode) == 3'd3 || $past(mode) == 3'd2));

  assert_reject_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> $past(cmd_valid));

  assert_mode_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);
endmodule

bind dev_mode_tracker dev_mode_tracker_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .power_cycle  (power_cycle),
  .hw_reset     (hw_reset),
  .volt_ok      (volt_ok),
  .cmd_valid    (cmd_valid),
  .mode         (mode),
  .addr_assigned(addr_assigned),
  .illegal_cmd  (illegal_cmd)
);

// File: tb/dev_mode_tracker_tb_top.sv
module dev_mode_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        power_cycle = 1'b0, hw_reset = 1'b0, cmd_valid = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        boot_supported = 1'b1, boot_done = 1'b0, volt_ok = 1'b1, irq_req = 1'b0;
  logic [2:0]  mode;
  logic        addr_assigned, illegal_cmd;

  int checks = 0;
  int fails  = 0;

  localparam int BOOT = 0, IDENT = 1, XFER = 2, IRQ = 3, INACT = 4;

  always #10 clk = ~clk;

  dev_mode_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .power_cycle(power_cycle), .hw_reset(hw_reset),
    .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
    .boot_supported(boot_supported), .boot_done(boot_done), .volt_ok(volt_ok),
    .irq_req(irq_req), .mode(mode), .addr_assigned(addr_assigned),
    .illegal_cmd(illegal_cmd)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_state(input string tag, input int m, input int a, input int ill);
    check({tag, " mode"}, int'(mode), m);
    check({tag, " addr"}, int'(addr_assigned), a);
    check({tag, " reject"}, int'(illegal_cmd), ill);
  endtask

  // Drive at a falling edge, outputs settle after the rising edge, sample at the next falling edge.
  task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_idx = idx; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: power_cycle = 1'b1;
      1: hw_reset    = 1'b1;
      2: boot_done   = 1'b1;
      default: irq_req = 1'b1;
    endcase
    @(negedge clk);
    power_cycle = 1'b0; hw_reset = 1'b0; boot_done = 1'b0; irq_req = 1'b0;
  endtask

  task automatic reach_xfer();
    pulse(0);
    pulse(2);
    send_cmd(6'd3, 32'hABCD_0000);
  endtask

  task automatic t_reset_R1();
    repeat (2) @(negedge clk);
    expect_state("R1 reset", BOOT, 0, 0);
  endtask

  task automatic t_boot_R4();
    repeat (3) @(negedge clk);
    check("R4 boot holds", int'(mode), BOOT);
    send_cmd(6'd2, 32'h0);
    expect_state("R11 cmd2 in boot", BOOT, 0, 1);
    @(negedge clk);
    check("R11 pulse one cycle", int'(illegal_cmd), 0);
    pulse(2);
    expect_state("R4 boot done", IDENT, 0, 0);
  endtask

  task automatic t_ident_R5();
    send_cmd(6'd40, 32'h0);
    expect_state("R9 cmd40 in ident", IDENT, 0, 1);
    send_cmd(6'd3, 32'h0000_1234);
    expect_state("R5 zero address", IDENT, 0, 1);
    send_cmd(6'd2, 32'h0);
    expect_state("R5 other cmd in ident", IDENT, 0, 0);
    send_cmd(6'd3, 32'h0001_0000);
    expect_state("R5 address set", XFER, 1, 0);
  endtask

  task automatic t_xfer_irq_R9();
    send_cmd(6'd3, 32'h5555_0000);
    expect_state("R11 cmd3 in xfer", XFER, 1, 1);
    send_cmd(6'd40, 32'h0);
    expect_state("R9 enter irq", IRQ, 1, 0);
    repeat (2) @(negedge clk);
    check("R10 irq holds", int'(mode), IRQ);
    pulse(3);
    expect_state("R10 request exit", XFER, 1, 0);
    send_cmd(6'd40, 32'h0);
    send_cmd(6'd13, 32'h0);
    expect_state("R10 command exit", XFER, 1, 0);
  endtask

  task automatic t_cmd0_R3();
    send_cmd(6'd0, 32'h0);
    expect_state("R3 cmd0 plain", IDENT, 0, 0);
    send_cmd(6'd3, 32'h0002_0000);
    check("R5 reassign", int'(mode), XFER);
    send_cmd(6'd0, 32'hF0F0_F0F0);
    expect_state("R3 cmd0 boot key", BOOT, 0, 0);
  endtask

  task automatic t_noboot_R4();
    @(negedge clk);
    boot_supported = 1'b0;
    @(negedge clk);
    check("R4 no boot support", int'(mode), IDENT);
    boot_supported = 1'b1;
  endtask

  task automatic t_hwreset_R2();
    reach_xfer();
    check("R2 setup", int'(mode), XFER);
    pulse(1);
    expect_state("R2 hw reset", BOOT, 0, 0);
  endtask

  task automatic t_sleep_R6();
    reach_xfer();
    send_cmd(6'd15, 32'h0);
    expect_state("R6 cmd15", INACT, 1, 0);
    send_cmd(6'd0, 32'hF0F0_F0F0);
    expect_state("R8 cmd0 ignored", INACT, 1, 0);
    send_cmd(6'd3, 32'h0);
    expect_state("R8 cmd3 ignored", INACT, 1, 0);
    pulse(1);
    expect_state("R8 hw reset ignored", INACT, 1, 0);
    pulse(0);
    expect_state("R1 power cycle exit", BOOT, 0, 0);
  endtask

  task automatic t_volt_R7();
    pulse(2);
    @(negedge clk);
    volt_ok = 1'b0;
    @(negedge clk);
    check("R7 voltage fault", int'(mode), INACT);
    volt_ok = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 stays after voltage recovers", int'(mode), INACT);
    pulse(0);
    check("R1 power cycle from fault", int'(mode), BOOT);
  endtask

  task automatic t_power_xfer_R1();
    reach_xfer();
    pulse(0);
    expect_state("R1 power cycle from xfer", BOOT, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_R1();
    t_boot_R4();
    t_ident_R5();
    t_xfer_irq_R9();
    t_cmd0_R3();
    t_noboot_R4();
    t_hwreset_R2();
    t_sleep_R6();
    t_volt_R7();
    t_power_xfer_R1();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule